// File: doc/BRIEF.md
# Multi-Content Rule Status Tracker

This block keeps the per-payload match state of a signature table. Every stored pattern content has one entry. A rule with one content has one entry, and that entry is its head. A rule with several contents is split into one entry per content. The entry of its longest content is the head, and the head lists the indices of the other entries of that rule. A head carries the rule identifier, and a lower identifier has higher priority.

While a payload is scanned, the pattern matcher sends a hit report for each content it confirms. Before it starts an expensive comparison, it can ask whether an entry is already flagged, so that an entry is never verified twice. Opening a new payload clears all flags in one cycle. Closing the scan starts a walk over the head entries only, at one head per cycle. For each head the walk checks the head's flag and the flags of all its listed siblings. It keeps the lowest identifier whose rule is complete. At the end it reports that rule, or it reports the payload as clean.

The table is loaded through a write port, one entry per write. Pattern comparison and hashing are done elsewhere.

Top module: `rule_status_tracker`

## Requirements
- R1: Directly after reset, no entry is a head and no entry is flagged, and `busy`, `res_valid`, `res_found` and `qry_ack` are low. A scan closed in this state reports clean.
- R2: After a hit report on an entry, a query on that entry returns matched until the next payload is opened.
- R3: A query accepted in one cycle is answered in the next cycle: `qry_ack` is high and `qry_matched` gives the entry's flag. The flag value includes a hit report and a payload open made in the same cycle as the query.
- R4: `scan_start` clears every flag in a single cycle. A hit report made in that same cycle belongs to the new payload and is kept.
- R5: A head with a sibling count of 0 is a single-content rule, and it is complete as soon as its own flag is set.
- R6: A head with sibling count c (at most MAX_SIB) is complete only when its own flag and the flags of all c indices in slots 0..c-1 of `cfg_sibs` are set. Slot k sits at bits [k*IW +: IW].
- R7: When several rules are complete, the result carries `res_found`=1 and the smallest rule identifier among them.
- R8: When no rule is complete, the result carries `res_found`=0 and `res_rule_id`=0. A flagged entry that is not a head never produces a result on its own.
- R9: `busy` is high from the cycle after an accepted `scan_end` until the result. `res_valid` is a one-cycle pulse in the first cycle in which `busy` is low again. The result arrives no later than N_ENTRIES+2 cycles after `scan_end`.
- R10: While `busy` is high, configuration writes, hit reports, queries, `scan_start` and `scan_end` are ignored, and no `qry_ack` is produced.
- R11: `res_found` and `res_rule_id` keep their value until the next `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | IW (4) | Entry index to write |
| cfg_head | input | 1 | Entry is the head of its rule |
| cfg_rule_id | input | ID_W (8) | Rule identifier (lower wins) |
| cfg_sib_cnt | input | CW (2) | Number of sibling links used |
| cfg_sibs | input | MAX_SIB*IW (12) | Sibling indices, slot k at [k*IW +: IW] |
| scan_start | input | 1 | Open a new payload (clear all flags) |
| hit_valid | input | 1 | Content confirmed in payload |
| hit_idx | input | IW (4) | Entry of the confirmed content |
| qry_valid | input | 1 | Ask whether an entry is flagged |
| qry_idx | input | IW (4) | Entry being asked about |
| qry_ack | output | 1 | Query answer valid |
| qry_matched | output | 1 | Entry already flagged |
| scan_end | input | 1 | Payload fully scanned; select result |
| busy | output | 1 | Head walk in progress |
| res_valid | output | 1 | Result pulse |
| res_found | output | 1 | A complete rule was found |
| res_rule_id | output | ID_W (8) | Winning rule identifier, 0 when clean |

## Verification
Two collisions are checked. In the first, a hit report and a query on the same entry arrive in the same cycle, and the answer must already show the flag. In the second, a payload open and a hit report share a cycle: the clear must take effect and the new hit must survive. The bench drives each pair at the same falling edge. It then checks the answer one cycle later, and it checks the earlier and new entries through further queries. It also sends hits and queries while the head walk is running, and it confirms through a later query and the reported rule that they changed nothing.

// File: rtl/rule_track_pkg.sv
package rule_track_pkg;
  typedef enum logic [0:0] {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/rule_ram.sv
// Entry descriptor store: one write port, one registered read port.
module rule_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flag_bank.sv
// Per-entry found flags with a single-cycle clear and a registered query port.
module flag_bank #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          set_v,
  input  logic [IW-1:0] set_idx,
  input  logic          qry_v,
  input  logic [IW-1:0] qry_idx,
  output logic          qry_ack,
  output logic          qry_matched,
  output logic [N-1:0]  flags
);
  logic [N-1:0] flags_nxt;

  // Clear first, then apply the hit so a hit on the opening cycle survives.
  always_comb begin
    flags_nxt = clear ? '0 : flags;
    if (set_v) flags_nxt[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags       <= '0;
      qry_ack     <= 1'b0;
      qry_matched <= 1'b0;
    end else begin
      flags       <= flags_nxt;
      qry_ack     <= qry_v;
      qry_matched <= qry_v ? flags_nxt[qry_idx] : 1'b0;
    end
  end
endmodule

// File: rtl/head_walker.sv
// Visits head entries one per cycle and keeps the best complete rule.
module head_walker
  import rule_track_pkg::*;
#(
  parameter int N       = 16,
  parameter int ID_W    = 8,
  parameter int MAX_SIB = 3,
  parameter int IW      = $clog2(N),
  parameter int CW      = $clog2(MAX_SIB + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [N-1:0]          head_map,
  input  logic [N-1:0]          flags,
  output logic [IW-1:0]         rd_addr,
  input  logic [ID_W-1:0]       rd_id,
  input  logic [CW-1:0]         rd_cnt,
  input  logic [MAX_SIB*IW-1:0] rd_sibs,
  output logic                  busy,
  output logic                  res_valid,
  output logic                  res_found,
  output logic [ID_W-1:0]       res_id
);
  walk_state_e     state;
  logic [N-1:0]    remaining;
  logic            pick_v;
  logic [IW-1:0]   pick_idx;
  logic            s1_v;
  logic [IW-1:0]   s1_idx;
  logic            best_v;
  logic [ID_W-1:0] best_id;
  logic            complete;
  logic            take;

  // Lowest-index head still to be visited.
  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (remaining[i]) begin
        pick_v   = 1'b1;
        pick_idx = IW'(i);
      end
    end
  end

  assign rd_addr = pick_idx;

  // Descriptor of s1_idx is on the RAM output this cycle.
  always_comb begin
    complete = flags[s1_idx];
    for (int k = 0; k < MAX_SIB; k++) begin
      if ((CW'(k) < rd_cnt) && !flags[rd_sibs[k*IW +: IW]]) complete = 1'b0;
    end
  end

  assign take = s1_v && complete && (!best_v || (rd_id < best_id));
  assign busy = (state == WK_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WK_IDLE;
      remaining <= '0;
      s1_v      <= 1'b0;
      s1_idx    <= '0;
      best_v    <= 1'b0;
      best_id   <= '0;
      res_valid <= 1'b0;
      res_found <= 1'b0;
      res_id    <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        WK_IDLE: begin
          s1_v <= 1'b0;
          if (start) begin
            remaining <= head_map;
            best_v    <= 1'b0;
            best_id   <= '0;
            state     <= WK_RUN;
          end
        end
        WK_RUN: begin
          s1_v   <= pick_v;
          s1_idx <= pick_idx;
          if (pick_v) remaining[pick_idx] <= 1'b0;
          if (take) begin
            best_v  <= 1'b1;
            best_id <= rd_id;
          end
          if (!pick_v && !s1_v) begin
            state     <= WK_IDLE;
            res_valid <= 1'b1;
            res_found <= best_v;
            res_id    <= best_v ? best_id : '0;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rule_status_tracker.sv
module rule_status_tracker #(
  parameter int  N_ENTRIES = 16,
  parameter int  ID_W      = 8,
  parameter int  MAX_SIB   = 3,
  localparam int IW        = $clog2(N_ENTRIES),
  localparam int CW        = $clog2(MAX_SIB + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [IW-1:0]         cfg_idx,
  input  logic                  cfg_head,
  input  logic [ID_W-1:0]       cfg_rule_id,
  input  logic [CW-1:0]         cfg_sib_cnt,
  input  logic [MAX_SIB*IW-1:0] cfg_sibs,
  input  logic                  scan_start,
  input  logic                  hit_valid,
  input  logic [IW-1:0]         hit_idx,
  input  logic                  qry_valid,
  input  logic [IW-1:0]         qry_idx,
  output logic                  qry_ack,
  output logic                  qry_matched,
  input  logic                  scan_end,
  output logic                  busy,
  output logic                  res_valid,
  output logic                  res_found,
  output logic [ID_W-1:0]       res_rule_id
);
  localparam int SW = MAX_SIB * IW;
  localparam int RW = ID_W + CW + SW;

  logic [N_ENTRIES-1:0] head_map;
  logic [N_ENTRIES-1:0] flags;
  logic [IW-1:0]        rd_addr;
  logic [RW-1:0]        rd_word;
  logic                 accept;

  assign accept = !busy;

  always_ff @(posedge clk) begin
    if (rst) head_map <= '0;
    else if (cfg_we && accept) head_map[cfg_idx] <= cfg_head;
  end

  rule_ram #(.DEPTH(N_ENTRIES), .DW(RW), .AW(IW)) u_ram (
    .clk   (clk),
    .we    (cfg_we && accept),
    .waddr (cfg_idx),
    .wdata ({cfg_rule_id, cfg_sib_cnt, cfg_sibs}),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  flag_bank #(.N(N_ENTRIES), .IW(IW)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .clear       (scan_start && accept),
    .set_v       (hit_valid && accept),
    .set_idx     (hit_idx),
    .qry_v       (qry_valid && accept),
    .qry_idx     (qry_idx),
    .qry_ack     (qry_ack),
    .qry_matched (qry_matched),
    .flags       (flags)
  );

  head_walker #(
    .N(N_ENTRIES), .ID_W(ID_W), .MAX_SIB(MAX_SIB), .IW(IW), .CW(CW)
  ) u_walk (
    .clk       (clk),
    .rst       (rst),
    .start     (scan_end && accept),
    .head_map  (head_map),
    .flags     (flags),
    .rd_addr   (rd_addr),
    .rd_id     (rd_word[RW-1 -: ID_W]),
    .rd_cnt    (rd_word[SW +: CW]),
    .rd_sibs   (rd_word[SW-1:0]),
    .busy      (busy),
    .res_valid (res_valid),
    .res_found (res_found),
    .res_id    (res_rule_id)
  );
endmodule

// File: rtl/rule_status_tracker_chk.sv
module rule_status_tracker_chk #(
  parameter int IW   = 4,
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            scan_start,
  input logic            hit_valid,
  input logic [IW-1:0]   hit_idx,
  input logic            qry_valid,
  input logic [IW-1:0]   qry_idx,
  input logic            qry_ack,
  input logic            qry_matched,
  input logic            scan_end,
  input logic            busy,
  input logic            res_valid,
  input logic            res_found,
  input logic [ID_W-1:0] res_rule_id
);
  p_ack_next_r3: assert property (@(posedge clk) disable iff (rst)
    (qry_valid && !busy) |=> qry_ack);

  p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (rst)
    !(qry_valid && !busy) |=> !qry_ack);

  p_same_cycle_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (qry_valid && !busy && hit_valid && hit_idx == qry_idx) |=> qry_matched);

  p_open_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (scan_start && !busy && qry_valid && !(hit_valid && hit_idx == qry_idx))
      |=> !qry_matched);

  p_walk_starts_r9: assert property (@(posedge clk) disable iff (rst)
    (scan_end && !busy) |=> busy);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> res_valid);

  p_clean_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_found) |-> (res_rule_id == '0));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_found) && $stable(res_rule_id)));
endmodule

bind rule_status_tracker rule_status_tracker_chk #(.IW(IW), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .scan_start  (scan_start),
  .hit_valid   (hit_valid),
  .hit_idx     (hit_idx),
  .qry_valid   (qry_valid),
  .qry_idx     (qry_idx),
  .qry_ack     (qry_ack),
  .qry_matched (qry_matched),
  .scan_end    (scan_end),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_found   (res_found),
  .res_rule_id (res_rule_id)
);

// File: tb/rule_status_tracker_test.sv
module rule_status_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int ID_W = 8;
  localparam int MS = 3;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic cfg_head = 1'b0;
  logic [ID_W-1:0] cfg_rule_id = '0;
  logic [CW-1:0] cfg_sib_cnt = '0;
  logic [MS*IW-1:0] cfg_sibs = '0;
  logic scan_start = 1'b0;
  logic hit_valid = 1'b0;
  logic [IW-1:0] hit_idx = '0;
  logic qry_valid = 1'b0;
  logic [IW-1:0] qry_idx = '0;
  logic qry_ack, qry_matched;
  logic scan_end = 1'b0;
  logic busy, res_valid, res_found;
  logic [ID_W-1:0] res_rule_id;

  int checks = 0;
  int errors = 0;

  bit m_head [N];
  int m_id   [N];
  int m_cnt  [N];
  int m_sib  [N][MS];
  bit m_flag [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rule_status_tracker uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_head(cfg_head),
    .cfg_rule_id(cfg_rule_id), .cfg_sib_cnt(cfg_sib_cnt), .cfg_sibs(cfg_sibs),
    .scan_start(scan_start), .hit_valid(hit_valid), .hit_idx(hit_idx),
    .qry_valid(qry_valid), .qry_idx(qry_idx), .qry_ack(qry_ack),
    .qry_matched(qry_matched), .scan_end(scan_end), .busy(busy),
    .res_valid(res_valid), .res_found(res_found), .res_rule_id(res_rule_id)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_result(output bit f, output int id);
    f = 1'b0;
    id = 0;
    for (int i = 0; i < N; i++) begin
      if (m_head[i] && m_flag[i]) begin
        bit ok;
        ok = 1'b1;
        for (int k = 0; k < MS; k++)
          if (k < m_cnt[i] && !m_flag[m_sib[i][k]]) ok = 1'b0;
        if (ok && (!f || m_id[i] < id)) begin
          f = 1'b1;
          id = m_id[i];
        end
      end
    end
  endfunction

  task automatic cfg_put(input int idx, input bit head, input int id, input int cnt,
                         input int s0, input int s1, input int s2);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_head = head; cfg_rule_id = ID_W'(id);
    cfg_sib_cnt = CW'(cnt);
    cfg_sibs = {IW'(s2), IW'(s1), IW'(s0)};
    m_head[idx] = head; m_id[idx] = id; m_cnt[idx] = cnt;
    m_sib[idx][0] = s0; m_sib[idx][1] = s1; m_sib[idx][2] = s2;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic hit(input int idx);
    hit_valid = 1'b1; hit_idx = IW'(idx);
    m_flag[idx] = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic query(input int idx, input string req);
    qry_valid = 1'b1; qry_idx = IW'(idx);
    @(negedge clk);
    qry_valid = 1'b0;
    check({req, " R3 ack"}, int'(qry_ack), 1);
    check({req, " flag"}, int'(qry_matched), int'(m_flag[idx]));
  endtask

  task automatic open_scan();
    scan_start = 1'b1;
    for (int i = 0; i < N; i++) m_flag[i] = 1'b0;
    @(negedge clk);
    scan_start = 1'b0;
  endtask

  task automatic wait_and_check(input string req, input bit ef, input int eid);
    int n;
    n = 0;
    while (!res_valid && n < N + 4) begin
      @(negedge clk);
      n++;
    end
    check("R9 result within bound", int'(res_valid), 1);
    check("R9 busy low at result", int'(busy), 0);
    check({req, " found"}, int'(res_found), int'(ef));
    check({req, " id"}, int'(res_rule_id), eid);
    @(negedge clk);
    check("R9 single pulse", int'(res_valid), 0);
  endtask

  task automatic close_scan(input string req);
    bit ef;
    int eid;
    model_result(ef, eid);
    scan_end = 1'b1;
    @(negedge clk);
    scan_end = 1'b0;
    check("R9 busy after end", int'(busy), 1);
    wait_and_check(req, ef, eid);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_head[i] = 0; m_id[i] = 0; m_cnt[i] = 0; m_flag[i] = 0;
      for (int k = 0; k < MS; k++) m_sib[i][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 res_found", int'(res_found), 0);
    check("R1 qry_ack", int'(qry_ack), 0);
    query(6, "R1 unflagged");
    close_scan("R1 empty table clean");

    // R5 / R8: single-content head and a lone non-head
    cfg_put(5, 1, 40, 0, 0, 0, 0);
    cfg_put(2, 0, 3, 0, 0, 0, 0);
    open_scan();
    hit(2);
    close_scan("R8 non-head alone clean");
    open_scan();
    hit(5);
    query(5, "R2 after hit");
    close_scan("R5 single content");

    // R6 / R7: multi-content rule
    cfg_put(9, 1, 10, 2, 3, 4, 0);
    cfg_put(3, 0, 11, 0, 0, 0, 0);
    cfg_put(4, 0, 12, 0, 0, 0, 0);
    open_scan();
    hit(9);
    hit(3);
    query(4, "R6 sibling not yet");
    close_scan("R6 partial rule clean");
    open_scan();
    hit(4); hit(9); hit(3); hit(5);
    close_scan("R7 lowest id wins");

    // R3: hit and query on same entry in same cycle
    open_scan();
    hit_valid = 1'b1; hit_idx = 4'd7; qry_valid = 1'b1; qry_idx = 4'd7;
    m_flag[7] = 1'b1;
    @(negedge clk);
    hit_valid = 1'b0; qry_valid = 1'b0;
    check("R3 same-cycle ack", int'(qry_ack), 1);
    check("R3 same-cycle matched", int'(qry_matched), 1);

    // R4: open and hit in same cycle
    hit(5);
    scan_start = 1'b1; hit_valid = 1'b1; hit_idx = 4'd9;
    qry_valid = 1'b1; qry_idx = 4'd5;
    for (int i = 0; i < N; i++) m_flag[i] = 1'b0;
    m_flag[9] = 1'b1;
    @(negedge clk);
    scan_start = 1'b0; hit_valid = 1'b0; qry_valid = 1'b0;
    check("R4 cleared on open", int'(qry_matched), 0);
    query(9, "R4 same-cycle hit kept");
    query(7, "R4 older flag cleared");

    // R10: input ignored while busy; R11 hold
    hit(3);
    begin
      bit ef;
      int eid;
      model_result(ef, eid);
      scan_end = 1'b1;
      @(negedge clk);
      scan_end = 1'b0;
      hit_valid = 1'b1; hit_idx = 4'd4; qry_valid = 1'b1; qry_idx = 4'd4;
      @(negedge clk);
      hit_valid = 1'b0; qry_valid = 1'b0;
      check("R10 no ack while busy", int'(qry_ack), 0);
      wait_and_check("R10 result unaffected", ef, eid);
      query(4, "R10 hit ignored");
      hit(4);
      repeat (3) @(negedge clk);
      check("R11 found held", int'(res_found), int'(ef));
      check("R11 id held", int'(res_rule_id), eid);
    end

    // Random rounds
    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < N; i++) begin
        bit h;
        int c;
        int s [MS];
        h = ($urandom % 3) == 0;
        c = h ? int'($urandom % (MS + 1)) : 0;
        for (int k = 0; k < MS; k++) begin
          s[k] = int'($urandom % N);
          if (s[k] == i) s[k] = (i + 1) % N;
        end
        cfg_put(i, h, (i * 37 + r * 11) % 256, c, s[0], s[1], s[2]);
      end
      open_scan();
      for (int j = 0; j < 6; j++) begin
        int e;
        e = int'($urandom % N);
        hit(e);
        if (m_head[e] && ($urandom % 2) == 1)
          for (int k = 0; k < m_cnt[e]; k++) hit(m_sib[e][k]);
        query(int'($urandom % N), "R2 random query");
      end
      close_scan("R7 random selection");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule